// File: doc/BRIEF.md
# Voice Slot Wall Clock with Interval Timer

This block keeps time for a 64-voice audio engine. A strobe from the engine marks the end of each channel service slot. The block steps a 6-bit slot index on each strobe, so every sample period holds 64 slots. When the slot index wraps from 63 back to 0, one sample period is complete and a free-running sample counter advances. Both values are packed into one 32-bit wall clock word that a register interface can return as it is.

A programmable interval timer counts sample periods downward. When its count ends, it emits a single-cycle terminal-count pulse. The interrupt logic uses this pulse to set its interval-timer pending bit. The rate is a 10-bit number of sample periods, and the value 0 selects 1024 periods. A new rate is loaded into the down-counter only at the next terminal count. The countdown already in progress finishes with its old length, which is why a rate change can take up to 1024 periods to become exact.

Top module: `voice_slot_clock`

## Requirements
- R1: While reset is asserted and directly after it is released, `slot_idx` is 0, `wall_word` is 0 and `timer_tc` is 0. The stored rate resets to 0, which means 1024 periods.
- R2: A clock edge with `slot_tick` high advances `slot_idx` by one, and 63 wraps to 0. An edge with `slot_tick` low leaves `slot_idx` unchanged.
- R3: The sample counter advances by one only on the edge where `slot_idx` wraps from 63 to 0. At all other edges it holds its value.
- R4: `wall_word` bits 5:0 carry the slot index and bits 25:6 carry the sample counter. Bits 31:26 read 0.
- R5: The sample counter wraps silently from all ones to 0. The bench exercises this with a 3-bit counter instance.
- R6: `timer_tc` is high for exactly one cycle. It rises on the same edge that wraps the slot index to 0, so it is high while `slot_idx` is 0.
- R7: With a stored rate of N, with N from 1 to 1023, consecutive pulses are N sample periods apart. A rate written in the middle of a countdown does not change that countdown, and it sets the length of the next one.
- R8: If a rate is written on the same edge as a terminal count, the reload on that edge uses the previously stored rate.
- R9: A stored rate of 0 gives a countdown of 1024 periods. The first countdown after reset is therefore 1024 periods long, so the first pulse comes with sample count 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | input | 1 | End-of-slot strobe; advances the slot index |
| rate_wr | input | 1 | Host write strobe for the timer rate |
| rate_wdata | input | 10 | Timer rate in sample periods; 0 means 1024 |
| slot_idx | output | 6 | Channel slot currently being serviced |
| wall_word | output | 32 | Packed wall clock: sample count above slot index |
| timer_tc | output | 1 | One-cycle interval timer terminal-count pulse |

## Verification
The assertions check the local stepping rules on every cycle. They cover the slot advance and hold, the sample counter moving only on a wrap (including its silent wrap), and the terminal-count pulse being one cycle long, following a wrap, and coinciding with slot 0. The countdown lengths cannot be checked cycle by cycle: the 1024-period default, a rate written in mid-count taking effect one countdown late, and a write that lands on the terminal edge itself. Only the bench's scenarios can show these, by comparing the sample counts at which pulses appear against a behavioural model.

// File: rtl/voice_clk_pkg.sv
package voice_clk_pkg;
    localparam int unsigned SLOT_BITS   = 6;
    localparam int unsigned SAMPLE_BITS = 20;
    localparam int unsigned RATE_BITS   = 10;
    localparam int unsigned WORD_BITS   = 32;
endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer
    import voice_clk_pkg::*;
#(
    parameter int unsigned SLOT_W = SLOT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [SLOT_W-1:0] slot,
    output logic              wrap
);
    localparam logic [SLOT_W-1:0] LAST = {SLOT_W{1'b1}};

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot = st_q.slot;
    assign wrap = tick && (st_q.slot == LAST);
endmodule

// File: rtl/sample_counter.sv
module sample_counter
    import voice_clk_pkg::*;
#(
    parameter int unsigned SAMPLE_W = SAMPLE_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                period_end,
    output logic [SAMPLE_W-1:0] count
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (period_end) begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import voice_clk_pkg::*;
#(
    parameter int unsigned RATE_W = RATE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_end,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_wdata,
    output logic              tc
);
    localparam int unsigned CNT_W = RATE_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << RATE_W;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [CNT_W-1:0]  left;
        logic              tc;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        reload = (st_q.rate == '0) ? FULL : {1'b0, st_q.rate};
        st_d    = st_q;
        st_d.tc = 1'b0;
        if (period_end) begin
            if (st_q.left == CNT_W'(1)) begin
                st_d.tc   = 1'b1;
                st_d.left = reload;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end
        if (rate_wr) begin
            st_d.rate = rate_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rate <= '0;
            st_q.left <= FULL;
            st_q.tc   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tc = st_q.tc;
endmodule

// File: rtl/voice_slot_clock.sv
module voice_slot_clock
    import voice_clk_pkg::*;
#(
    parameter int unsigned SLOT_W   = SLOT_BITS,
    parameter int unsigned SAMPLE_W = SAMPLE_BITS,
    parameter int unsigned RATE_W   = RATE_BITS,
    parameter int unsigned WORD_W   = WORD_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_tick,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_wdata,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [WORD_W-1:0] wall_word,
    output logic              timer_tc
);
    localparam int unsigned USED_W = SLOT_W + SAMPLE_W;
    localparam int unsigned PAD_W  = WORD_W - USED_W;

    logic                period_end;
    logic [SAMPLE_W-1:0] samples;

    slot_sequencer #(.SLOT_W(SLOT_W)) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (slot_tick),
        .slot (slot_idx),
        .wrap (period_end)
    );

    sample_counter #(.SAMPLE_W(SAMPLE_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_end(period_end),
        .count     (samples)
    );

    interval_timer #(.RATE_W(RATE_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_end(period_end),
        .rate_wr   (rate_wr),
        .rate_wdata(rate_wdata),
        .tc        (timer_tc)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign wall_word = {{PAD_W{1'b0}}, samples, slot_idx};
        end else begin : g_nopad
            assign wall_word = {samples, slot_idx};
        end
    endgenerate
endmodule

// File: rtl/voice_slot_clock_chk.sv
module voice_slot_clock_chk #(
    parameter int unsigned SLOT_W   = 6,
    parameter int unsigned SAMPLE_W = 20,
    parameter int unsigned WORD_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_tick,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [WORD_W-1:0] wall_word,
    input logic              timer_tc
);
    logic [SAMPLE_W-1:0] smp;
    logic                last_slot;
    assign smp       = wall_word[SLOT_W +: SAMPLE_W];
    assign last_slot = (slot_idx == {SLOT_W{1'b1}});

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> slot_idx == SLOT_W'($past(slot_idx) + 1'b1));
    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> $stable(slot_idx));
    // R3
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_tick && last_slot) |=> $stable(smp));
    // R3 R5
    sample_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && last_slot) |=> smp == SAMPLE_W'($past(smp) + 1'b1));
    // R6
    tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_tc |=> !timer_tc);
    // R6
    tc_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_tc |-> slot_idx == '0);
    // R6
    tc_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_tc) |-> $past(slot_tick && last_slot));
endmodule

bind voice_slot_clock voice_slot_clock_chk #(
    .SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_tick(slot_tick),
    .slot_idx (slot_idx),
    .wall_word(wall_word),
    .timer_tc (timer_tc)
);

// File: tb/sim_voice_slot_clock.sv
`timescale 1ns/1ps
module sim_voice_slot_clock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic [9:0] wdata = '0;
    logic [5:0] slot0, slot1;
    logic [31:0] word0, word1;
    logic       tc0, tc1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    voice_slot_clock u0 (
        .clk(clk), .rst_n(rst_n), .slot_tick(tick), .rate_wr(wr),
        .rate_wdata(wdata), .slot_idx(slot0), .wall_word(word0), .timer_tc(tc0)
    );

    voice_slot_clock #(.SAMPLE_W(3)) u1 (
        .clk(clk), .rst_n(rst_n), .slot_tick(tick), .rate_wr(wr),
        .rate_wdata(wdata), .slot_idx(slot1), .wall_word(word1), .timer_tc(tc1)
    );

    // behavioural reference
    int m_slot = 0, m_samp = 0, m_left = 1024, m_rate = 0;
    bit m_tc = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_slot = 0; m_samp = 0; m_left = 1024; m_rate = 0; m_tc = 0;
        end else begin
            m_tc = 0;
            if (tick) begin
                if (m_slot == 63) begin
                    m_slot = 0;
                    m_samp = (m_samp + 1) % (1 << 20);
                    m_left = m_left - 1;
                    if (m_left == 0) begin
                        m_tc = 1;
                        m_left = (m_rate == 0) ? 1024 : m_rate;
                    end
                end else begin
                    m_slot = m_slot + 1;
                end
            end
            if (wr) m_rate = int'(wdata);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    int tc_at[$];
    int u1_wraps = 0;
    int prev1 = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(slot0) == m_slot, "R2 slot", int'(slot0), m_slot);
            chk(int'(word0[25:6]) == m_samp, "R3 sample", int'(word0[25:6]), m_samp);
            chk(word0 == 32'((m_samp << 6) | m_slot), "R4 word", int'(word0), (m_samp << 6) | m_slot);
            chk(tc0 == m_tc, "R6 tc", int'(tc0), int'(m_tc));
            chk(int'(word1[8:6]) == (m_samp % 8), "R5 narrow sample", int'(word1[8:6]), m_samp % 8);
            chk(word1[31:9] == '0, "R4 narrow pad", int'(word1[31:9]), 0);
            if (tc0) tc_at.push_back(int'(word0[25:6]));
            if (prev1 == 7 && int'(word1[8:6]) == 0) u1_wraps++;
            prev1 = int'(word1[8:6]);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int exp_tc[10] = '{1024, 1029, 1030, 1031, 1032, 1033, 1034, 1035, 1038, 1041};
        int held;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(slot0 == 0 && word0 == 0 && tc0 == 0, "R1 in reset", int'(word0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(slot0 == 0 && word0 == 0 && tc0 == 0, "R1 after release", int'(word0), 0);
        // R7: write rate 5 early; current 1024 countdown unaffected
        wr = 1'b1; wdata = 10'd5;
        @(negedge clk);
        wr = 1'b0;
        // gappy ticks, R2 hold
        for (int i = 0; i < 300; i++) begin
            tick = (i % 3 != 0);
            held = int'(slot0);
            @(negedge clk);
            if (i % 3 == 0) chk(int'(slot0) == held, "R2 hold without tick", int'(slot0), held);
        end
        tick = 1'b1;
        while (int'(word0[25:6]) < 1026) @(negedge clk);
        // R7: mid-count write of 1
        wr = 1'b1; wdata = 10'd1;
        @(negedge clk);
        wr = 1'b0;
        // R8: write 3 on the very edge of a terminal count
        while (!(slot0 == 6'd63 && int'(word0[25:6]) == 1033)) @(negedge clk);
        wr = 1'b1; wdata = 10'd3;
        @(negedge clk);
        wr = 1'b0;
        while (int'(word0[25:6]) < 1042) @(negedge clk);

        chk(tc_at.size() == 10, "R6 pulse count", tc_at.size(), 10);
        for (int k = 0; k < 10 && k < tc_at.size(); k++) begin
            string tag;
            tag = (k == 0) ? "R9 first pulse" : (k == 1) ? "R7 late rate" :
                  (k == 7 || k == 8) ? "R8 same-edge write" : "R7 rate one";
            chk(tc_at[k] == exp_tc[k], tag, tc_at[k], exp_tc[k]);
        end
        chk(u1_wraps > 0, "R5 silent wrap", u1_wraps, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule